// File: doc/BRIEF.md
# Inverted Page Table Translator

This block translates logical addresses to physical ones through a table that has exactly one entry for each physical page of memory. Each entry holds the logical page number that is currently placed in its physical page, plus a valid bit. A lookup compares the logical page number of the incoming address against every entry at once. The position of the matching entry, produced by a fixed priority encoder, is the physical page number. No physical page number is stored anywhere in the table.

Software owns the table and fills it through a single write port. There is no table-walk hardware. A lookup that matches no valid entry means that the page is not resident in memory. The block then raises a fault, and software fetches the page and rewrites an entry. The page size follows the installed memory size, so 128 entries always cover the whole of physical memory. The memory-size selector picks how many low address bits form the in-page offset. Only the bits above the offset are compared.

Top module: `inv_page_cam`

## Requirements
- R1: While `rst_n` is low and after it is released, every entry is invalid and `rsp_valid` is 0.
- R2: When `wr_en` is high at a rising edge, entry `wr_idx` takes `wr_lpn` as its logical page number and `wr_valid` as its valid bit. Lookups issued from the next cycle on see the new contents.
- R3: A lookup presented with `lk_valid` high at a rising edge produces `rsp_valid` = 1 at the next rising edge. `rsp_valid` is 0 in every cycle that follows a cycle without a lookup.
- R4: On a hit (`rsp_hit` = 1, `rsp_fault` = 0), `rsp_ppn` equals the index of the matching valid entry.
- R5: `mem_cfg` selects the page size: 0 gives 8 KiB pages (13 offset bits), 1 gives 16 KiB pages (14 bits), and 2 or 3 give 32 KiB pages (15 bits). The compared logical page number is `lk_vaddr` shifted right by the offset width.
- R6: `rsp_offset` equals the low offset-width bits of `lk_vaddr`, with the bits above them zero. On a hit, `rsp_paddr` = (`rsp_ppn` << offset width) | `rsp_offset`.
- R7: When no valid entry matches, `rsp_fault` = 1, `rsp_hit` = 0, `rsp_multi` = 0, and `rsp_ppn` and `rsp_paddr` are 0.
- R8: An entry written with `wr_valid` = 0 never matches, whatever logical page number it holds.
- R9: When several valid entries match, the lowest index wins and `rsp_multi` = 1. With a single match, `rsp_multi` = 0.
- R10: A lookup and a write in the same cycle compare against the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_cfg | input | 2 | Installed memory size selector; sets the page size |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 7 | Entry written, which is also the physical page number |
| wr_lpn | input | 13 | Logical page number stored in the entry |
| wr_valid | input | 1 | Valid bit stored in the entry |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 26 | Logical address to translate |
| rsp_valid | output | 1 | Result present, one cycle after the request |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_fault | output | 1 | No valid entry matched; page not resident |
| rsp_multi | output | 1 | More than one valid entry matched |
| rsp_ppn | output | 7 | Physical page number |
| rsp_offset | output | 15 | In-page offset passed through |
| rsp_paddr | output | 22 | Translated physical address |

## Verification
The assertions assume three things about the inputs:
- `mem_cfg` stays constant while a lookup is in flight.
- `wr_idx` names an existing entry.
- No input is unknown once reset has been released.

The stimulus changes `mem_cfg` only between lookups, never while one is pending. It writes only indices below 128. It drives every input to a defined value from time zero. Duplicate logical page numbers are placed in the table on purpose, so that the priority and multi-hit paths are exercised rather than assumed away.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  // Installed memory size selector values
  typedef enum logic [1:0] {
    MEM_1M  = 2'd0,
    MEM_2M  = 2'd1,
    MEM_4M  = 2'd2,
    MEM_BIG = 2'd3
  } mem_cfg_e;

  // Offset width grows one bit per memory-size step, saturating at max_w
  function automatic int unsigned page_shift(input logic [1:0] cfg,
                                             input int unsigned min_w,
                                             input int unsigned max_w);
    int unsigned s;
    s = min_w + int'(cfg);
    if (s > max_w) s = max_w;
    return s;
  endfunction

endpackage

// File: rtl/ipt_entry_array.sv
module ipt_entry_array #(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned TAG_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_lpn,
  input  logic               wr_valid,
  input  logic [TAG_W-1:0]   cmp_tag,
  output logic [ENTRIES-1:0] match_vec
);

  logic [ENTRIES-1:0] valid_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic [TAG_W-1:0] tag_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    // valid bit: reset to invalid, written under enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q[g] <= 1'b0;
      else if (sel) valid_q[g] <= wr_valid;
    end

    // tag storage: no reset, written under enable
    always_ff @(posedge clk) begin
      if (sel) tag_q <= wr_lpn;
    end

    assign match_vec[g] = valid_q[g] && (tag_q == cmp_tag);
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (valid_q == '0));

endmodule

// File: rtl/ipt_prio_enc.sv
module ipt_prio_enc #(
  parameter int unsigned N     = 128,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     match_vec,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic             multi
);

  localparam logic [N-1:0] ONE = N'(1);

  always_comb begin
    idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
    found = |match_vec;
    multi = found && ((match_vec & (match_vec - ONE)) != '0);
  end

  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (match_vec[idx] && ((match_vec & ((ONE << idx) - ONE)) == '0)));

  // R9
  multi_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi == ($countones(match_vec) > 1));

endmodule

// File: rtl/inv_page_cam.sv
module inv_page_cam #(
  parameter int unsigned ENTRIES   = 128,
  parameter int unsigned VA_W      = 26,
  parameter int unsigned MIN_OFF_W = 13,
  parameter int unsigned MAX_OFF_W = 15,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned TAG_W    = VA_W - MIN_OFF_W,
  localparam int unsigned PA_W     = IDX_W + MAX_OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mem_cfg,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_lpn,
  input  logic                 wr_valid,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_vaddr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_fault,
  output logic                 rsp_multi,
  output logic [IDX_W-1:0]     rsp_ppn,
  output logic [MAX_OFF_W-1:0] rsp_offset,
  output logic [PA_W-1:0]      rsp_paddr
);

  int unsigned          off_w;
  logic [TAG_W-1:0]     lk_tag;
  logic [MAX_OFF_W-1:0] off_mask;
  logic [ENTRIES-1:0]   match_vec;
  logic                 enc_found;
  logic [IDX_W-1:0]     enc_idx;
  logic                 enc_multi;

  // next-state values of the result register
  logic                 hit_n;
  logic                 multi_n;
  logic [IDX_W-1:0]     ppn_n;
  logic [MAX_OFF_W-1:0] offset_n;
  logic [PA_W-1:0]      paddr_n;

  always_comb begin
    off_w    = ipt_pkg::page_shift(mem_cfg, MIN_OFF_W, MAX_OFF_W);
    lk_tag   = TAG_W'(lk_vaddr >> off_w);
    off_mask = (MAX_OFF_W'(1) << off_w) - MAX_OFF_W'(1);
  end

  ipt_entry_array #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_lpn    (wr_lpn),
    .wr_valid  (wr_valid),
    .cmp_tag   (lk_tag),
    .match_vec (match_vec)
  );

  ipt_prio_enc #(
    .N     (ENTRIES),
    .IDX_W (IDX_W)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_vec (match_vec),
    .found     (enc_found),
    .idx       (enc_idx),
    .multi     (enc_multi)
  );

  always_comb begin
    hit_n    = enc_found;
    multi_n  = enc_multi;
    offset_n = lk_vaddr[MAX_OFF_W-1:0] & off_mask;
    ppn_n    = enc_found ? enc_idx : '0;
    paddr_n  = enc_found ? ((PA_W'(enc_idx) << off_w) | PA_W'(offset_n)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_multi  <= 1'b0;
      rsp_ppn    <= '0;
      rsp_offset <= '0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit    <= hit_n;
        rsp_fault  <= !hit_n;
        rsp_multi  <= multi_n;
        rsp_ppn    <= ppn_n;
        rsp_offset <= offset_n;
        rsp_paddr  <= paddr_n;
      end
    end
  end

  // R3
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R3
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R7
  hit_xor_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_fault));

  // R7
  fault_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_ppn == '0 && rsp_paddr == '0 && !rsp_multi));

  // R6
  paddr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |->
      (rsp_paddr[MIN_OFF_W-1:0] == rsp_offset[MIN_OFF_W-1:0]));

endmodule

// File: tb/inv_page_cam_tb.sv
module inv_page_cam_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mem_cfg;
  logic        wr_en;
  logic [6:0]  wr_idx;
  logic [12:0] wr_lpn;
  logic        wr_valid;
  logic        lk_valid;
  logic [25:0] lk_vaddr;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_multi;
  logic [6:0]  rsp_ppn;
  logic [14:0] rsp_offset;
  logic [21:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [12:0] m_lpn [128];
  bit          m_v   [128];

  inv_page_cam u_dut (
    .clk(clk), .rst_n(rst_n), .mem_cfg(mem_cfg),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_lpn(wr_lpn), .wr_valid(wr_valid),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_multi(rsp_multi), .rsp_ppn(rsp_ppn), .rsp_offset(rsp_offset),
    .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_off(input logic [1:0] cfg);
    return (cfg == 2'd0) ? 13 : (cfg == 2'd1) ? 14 : 15;
  endfunction

  task automatic write_entry(input int idx, input logic [12:0] lpn, input bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'(idx); wr_lpn = lpn; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    m_lpn[idx] = lpn; m_v[idx] = v;
  endtask

  // expected result from the model, then lookup and compare everything
  task automatic do_lookup(input logic [25:0] va, input string req);
    int off; logic [12:0] tag; bit f; int ix; int cnt;
    logic [14:0] ofs; logic [21:0] pa;
    off = exp_off(mem_cfg);
    tag = 13'(va >> off);
    f = 0; ix = 0; cnt = 0;
    for (int i = 127; i >= 0; i--)
      if (m_v[i] && m_lpn[i] == tag) begin f = 1; ix = i; cnt++; end
    ofs = 15'(va & ((26'd1 << off) - 26'd1));
    pa  = f ? ((22'(ix) << off) | 22'(ofs)) : 22'd0;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R3", {req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(req, "hit",    32'(rsp_hit),    32'(f));
    chk(req, "fault",  32'(rsp_fault),  32'(!f));
    chk(req, "ppn",    32'(rsp_ppn),    f ? 32'(ix) : 32'd0);
    chk(req, "offset", 32'(rsp_offset), 32'(ofs));
    chk(req, "paddr",  32'(rsp_paddr),  32'(pa));
    chk(req, "multi",  32'(rsp_multi),  32'(cnt > 1));
    @(negedge clk);
    chk("R3", {req, " rsp_valid drop"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    mem_cfg = 2'd0;
    do_lookup(26'h0000000, "R1");
    do_lookup(26'h3ffffff, "R1");
  endtask

  task automatic t_basic();
    mem_cfg = 2'd0;
    write_entry(5, 13'h023, 1);
    write_entry(100, 13'h1abc, 1);
    write_entry(127, 13'h0001, 1);
    do_lookup({13'h023, 13'h0abc}, "R4");
    do_lookup({13'h1abc, 13'h1fff}, "R6");
    do_lookup({13'h0001, 13'h0000}, "R4");
    do_lookup({13'h0777, 13'h0123}, "R7");
  endtask

  task automatic t_pagesize();
    write_entry(9, 13'h0055, 1);
    mem_cfg = 2'd1;
    do_lookup((26'h0055 << 14) | 26'h3a5a, "R5");
    do_lookup((26'h0055 << 13) | 26'h0001, "R5");
    mem_cfg = 2'd2;
    do_lookup((26'h0055 << 15) | 26'h7fff, "R5");
    mem_cfg = 2'd3;
    do_lookup((26'h0055 << 15) | 26'h4321, "R6");
    do_lookup((26'h0055 << 14), "R5");
    mem_cfg = 2'd0;
    do_lookup((26'h0055 << 13) | 26'h1234, "R6");
  endtask

  task automatic t_invalidate();
    mem_cfg = 2'd0;
    write_entry(5, 13'h023, 0);
    do_lookup({13'h023, 13'h0010}, "R8");
    write_entry(5, 13'h023, 1);
    do_lookup({13'h023, 13'h0010}, "R2");
  endtask

  task automatic t_multi();
    mem_cfg = 2'd0;
    write_entry(20, 13'h0bee, 1);
    do_lookup({13'h0bee, 13'h0044}, "R9");
    write_entry(10, 13'h0bee, 1);
    write_entry(60, 13'h0bee, 1);
    do_lookup({13'h0bee, 13'h0044}, "R9");
    write_entry(10, 13'h0000, 0);
    do_lookup({13'h0bee, 13'h0045}, "R9");
  endtask

  task automatic t_same_cycle();
    mem_cfg = 2'd0;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'd30; wr_lpn = 13'h0ace; wr_valid = 1'b1;
    lk_valid = 1'b1; lk_vaddr = {13'h0ace, 13'h0002};
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R10", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R10", "fault on old contents", 32'(rsp_fault), 32'd1);
    chk("R10", "hit on old contents", 32'(rsp_hit), 32'd0);
    m_lpn[30] = 13'h0ace; m_v[30] = 1;
    do_lookup({13'h0ace, 13'h0002}, "R10");
  endtask

  initial begin
    rst_n = 1'b0; mem_cfg = 2'd0;
    wr_en = 1'b0; wr_idx = '0; wr_lpn = '0; wr_valid = 1'b0;
    lk_valid = 1'b0; lk_vaddr = '0;
    for (int i = 0; i < 128; i++) begin m_lpn[i] = '0; m_v[i] = 0; end
    #1;
    t_reset();
    t_basic();
    t_pagesize();
    t_invalidate();
    t_multi();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule